// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

A behavioural model of a synchronous static RAM. It has registered inputs, a registered read pipeline and a two-bit burst address counter. Every rising clock edge is decoded into one of four commands: deselect, begin a read burst, begin a write burst, or continue. The decode uses three chip enables, two competing address strobes (a processor strobe and a controller strobe), a burst-advance input, and byte-lane write enables. Writes commit at the edge that carries the address or the continue command. Reads leave through an output register, one edge after the address edge.

The data word is split into byte lanes of nine bits each (eight data bits and one parity bit). A global write enable writes every lane. Otherwise a byte-write gate, combined with per-lane enables, selects the lanes to write. A burst walks four words within an aligned block, in linear or interleaved order. The output drive can be forced off at any time by an asynchronous output enable. A sleep input freezes all state while it is high.

Top module: `sync_burst_sram`

## Requirements
- R1: The chip is selected at an edge only when cs1_n_i=0, cs2_i=1 and cs3_n_i=0 at that edge.
- R2: pstb_n_i=0 with the chip selected begins a read burst at addr_i, whatever the write enables are.
- R3: pstb_n_i=0 while not selected is a deselect. cstb_n_i=0 while not selected is a deselect, including cs1_n_i=1 with pstb_n_i=1.
- R4: pstb_n_i=1, cstb_n_i=0 and selected begins a burst at addr_i. The burst is a write if the combined write signal is active, otherwise a read.
- R5: With both strobes high, an active burst continues its operation. It uses the next burst address when adv_n_i=0 and the current address when adv_n_i=1. The chip enables are not looked at.
- R6: The combined write signal is active when gwe_n_i=0, or when bwe_n_i=0 and any bit of lane_we_n_i is 0. bwe_n_i=0 with all lane enables high is a read.
- R7: Lane k occupies data bits [9k+8:9k]. gwe_n_i=0 writes all lanes. Otherwise only the lanes whose lane_we_n_i bit is 0 are written.
- R8: After a deselect, continue cycles perform no access until a new begin. rdata_oe_o is 0 after the edge that follows the deselect edge.
- R9: For a read address taken at edge k, the data appears on rdata_o with rdata_oe_o=1 after edge k+1. A read issued right after a write to the same word returns the new data.
- R10: Write data on wdata_i is captured at the same edge as the write address or the continue command.
- R11: oe_n_i=1 forces rdata_oe_o to 0 and rdata_o to 0 at once, without a clock edge. Both are restored when oe_n_i returns to 0.
- R12: While sleep_i=1, commands are ignored and the memory, burst state and outputs hold. Operation resumes when sleep_i returns to 0.
- R13: The burst offset for step n from base low bits b is (b+n) mod 4 when lin_mode_i=1 and b XOR n when lin_mode_i=0. The upper address bits are kept.
- R14: After reset the block is deselected with rdata_oe_o=0, and the memory reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs1_n_i | input | 1 | Chip enable one, active low |
| cs2_i | input | 1 | Chip enable two, active high |
| cs3_n_i | input | 1 | Chip enable three, active low |
| pstb_n_i | input | 1 | Processor address strobe, active low |
| cstb_n_i | input | 1 | Controller address strobe, active low |
| adv_n_i | input | 1 | Burst advance, active low |
| gwe_n_i | input | 1 | Global write enable, active low |
| bwe_n_i | input | 1 | Byte-write gate, active low |
| lane_we_n_i | input | LANES | Per-lane write enables, active low |
| lin_mode_i | input | 1 | Burst order: 1 linear, 0 interleaved |
| oe_n_i | input | 1 | Asynchronous output enable, active low |
| sleep_i | input | 1 | Sleep; freezes the block while high |
| addr_i | input | AW | External word address |
| wdata_i | input | LANES*LW | Write data |
| rdata_o | output | LANES*LW | Read data, zero when not driven |
| rdata_oe_o | output | 1 | Output drive enable; 0 means high impedance |

## Verification
The bench aims at the strobe priority rules, where three mistakes are each caught by a read-back mismatch. A design that honoured write enables under the processor strobe would corrupt memory. One that let a deselected continue cycle keep reading would hold rdata_oe_o high. One that checked only one enable would start a burst while unselected. Byte-masked writes with the gate low and no lane enabled must leave memory untouched; a design that treated that case as a write would lose data. Burst wrap in both orders, a read issued right after a write to the same word, and the no-advance continue cycle (a wrong counter returns a neighbouring word) each show up as a wrong word at a fixed cycle. Sleep is checked by a command issued while asleep; a design that acted on it changes the later read-back.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  typedef enum logic [1:0] {
    CMD_DESEL = 2'd0,
    CMD_RD    = 2'd1,
    CMD_WR    = 2'd2,
    CMD_CONT  = 2'd3
  } sbs_cmd_e;
endpackage

// File: rtl/sbs_cmd_decode.sv
module sbs_cmd_decode #(
  parameter int LANES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs1_n_i,
  input  logic              cs2_i,
  input  logic              cs3_n_i,
  input  logic              pstb_n_i,
  input  logic              cstb_n_i,
  input  logic              gwe_n_i,
  input  logic              bwe_n_i,
  input  logic [LANES-1:0]  lane_we_n_i,
  output sbs_pkg::sbs_cmd_e cmd_o,
  output logic [LANES-1:0]  lane_wr_o
);
  import sbs_pkg::*;

  logic sel;
  logic wr_act;

  assign sel = !cs1_n_i && cs2_i && !cs3_n_i;

  always_comb begin
    if (!gwe_n_i)      lane_wr_o = '1;
    else if (!bwe_n_i) lane_wr_o = ~lane_we_n_i;
    else               lane_wr_o = '0;
  end

  assign wr_act = |lane_wr_o;

  // processor strobe has priority and never writes
  always_comb begin
    if (!pstb_n_i)      cmd_o = sel ? CMD_RD : CMD_DESEL;
    else if (!cstb_n_i) cmd_o = !sel ? CMD_DESEL : (wr_act ? CMD_WR : CMD_RD);
    else                cmd_o = CMD_CONT;
  end

  // R1
  sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_RD || cmd_o == CMD_WR) |-> (!cs1_n_i && cs2_i && !cs3_n_i));

  // R2
  pstb_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pstb_n_i && cmd_o != CMD_DESEL) |-> (cmd_o == CMD_RD));
endmodule

// File: rtl/sbs_burst_addr.sv
module sbs_burst_addr #(
  parameter int AW = 6,
  parameter int BB = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] base_i,
  input  logic [BB-1:0] cnt_i,
  input  logic          lin_i,
  output logic [AW-1:0] addr_o
);
  logic [BB-1:0] off_lin;
  logic [BB-1:0] off_ilv;

  assign off_lin = base_i[BB-1:0] + cnt_i;
  assign off_ilv = base_i[BB-1:0] ^ cnt_i;
  assign addr_o  = {base_i[AW-1:BB], lin_i ? off_lin : off_ilv};

  // R13
  first_beat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i == '0) |-> (addr_o == base_i));
endmodule

// File: rtl/sbs_mem.sv
module sbs_mem #(
  parameter int AW    = 6,
  parameter int LANES = 2,
  parameter int LW    = 9
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [LANES-1:0]    lane_wr_i,
  input  logic [AW-1:0]       waddr_i,
  input  logic [LANES*LW-1:0] wdata_i,
  input  logic [AW-1:0]       raddr_i,
  output logic [LANES*LW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LW-1:0] lane_mem [DEPTH];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int i = 0; i < DEPTH; i++) lane_mem[i] <= '0;
      end else if (lane_wr_i[l]) begin
        lane_mem[waddr_i] <= wdata_i[l*LW +: LW];
      end
    end

    assign rdata_o[l*LW +: LW] = lane_mem[raddr_i];
  end
endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram #(
  parameter int AW    = 6,
  parameter int LANES = 2,
  parameter int LW    = 9
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cs1_n_i,
  input  logic                cs2_i,
  input  logic                cs3_n_i,
  input  logic                pstb_n_i,
  input  logic                cstb_n_i,
  input  logic                adv_n_i,
  input  logic                gwe_n_i,
  input  logic                bwe_n_i,
  input  logic [LANES-1:0]    lane_we_n_i,
  input  logic                lin_mode_i,
  input  logic                oe_n_i,
  input  logic                sleep_i,
  input  logic [AW-1:0]       addr_i,
  input  logic [LANES*LW-1:0] wdata_i,
  output logic [LANES*LW-1:0] rdata_o,
  output logic                rdata_oe_o
);
  import sbs_pkg::*;

  localparam int DW = LANES * LW;
  localparam int BB = 2;

  sbs_cmd_e         cmd;
  logic [LANES-1:0] lane_wr;
  logic             act_q, op_wr_q;
  logic [AW-1:0]    base_q;
  logic [BB-1:0]    cnt_q;
  logic             rd_vld_q, drive_q;
  logic [AW-1:0]    rd_addr_q;
  logic [DW-1:0]    dout_q, mem_rdata;

  logic             start, cont;
  logic [AW-1:0]    base_use, acc_addr;
  logic [BB-1:0]    cnt_use;
  logic             acc_rd, acc_wr;
  logic [LANES-1:0] mem_lane_wr;

  sbs_cmd_decode #(.LANES(LANES)) u_dec (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs1_n_i    (cs1_n_i),
    .cs2_i      (cs2_i),
    .cs3_n_i    (cs3_n_i),
    .pstb_n_i   (pstb_n_i),
    .cstb_n_i   (cstb_n_i),
    .gwe_n_i    (gwe_n_i),
    .bwe_n_i    (bwe_n_i),
    .lane_we_n_i(lane_we_n_i),
    .cmd_o      (cmd),
    .lane_wr_o  (lane_wr)
  );

  assign start    = (cmd == CMD_RD) || (cmd == CMD_WR);
  assign cont     = (cmd == CMD_CONT) && act_q;
  assign base_use = start ? addr_i : base_q;
  assign cnt_use  = start ? '0 : (adv_n_i ? cnt_q : cnt_q + 1'b1);

  sbs_burst_addr #(.AW(AW), .BB(BB)) u_addr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .base_i(base_use),
    .cnt_i (cnt_use),
    .lin_i (lin_mode_i),
    .addr_o(acc_addr)
  );

  assign acc_rd      = !sleep_i && ((cmd == CMD_RD) || (cont && !op_wr_q));
  assign acc_wr      = !sleep_i && ((cmd == CMD_WR) || (cont && op_wr_q));
  assign mem_lane_wr = lane_wr & {LANES{acc_wr}};

  sbs_mem #(.AW(AW), .LANES(LANES), .LW(LW)) u_mem (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .lane_wr_i(mem_lane_wr),
    .waddr_i  (acc_addr),
    .wdata_i  (wdata_i),
    .raddr_i  (rd_addr_q),
    .rdata_o  (mem_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q     <= 1'b0;
      op_wr_q   <= 1'b0;
      base_q    <= '0;
      cnt_q     <= '0;
      rd_vld_q  <= 1'b0;
      rd_addr_q <= '0;
      drive_q   <= 1'b0;
      dout_q    <= '0;
    end else if (!sleep_i) begin
      case (cmd)
        CMD_DESEL: act_q <= 1'b0;
        CMD_RD, CMD_WR: begin
          act_q   <= 1'b1;
          op_wr_q <= (cmd == CMD_WR);
          base_q  <= addr_i;
          cnt_q   <= '0;
        end
        default: if (act_q) cnt_q <= cnt_use;
      endcase
      rd_vld_q  <= acc_rd;
      rd_addr_q <= acc_addr;
      drive_q   <= rd_vld_q;
      dout_q    <= mem_rdata;
    end
  end

  assign rdata_oe_o = drive_q && !oe_n_i;
  assign rdata_o    = rdata_oe_o ? dout_q : '0;

  // R8
  desel_float_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd == CMD_DESEL && !sleep_i) |=> !rd_vld_q);

  // R9
  pipe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_vld_q && !sleep_i) |=> drive_q);

  // R5
  no_adv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd == CMD_CONT && act_q && adv_n_i && !sleep_i) |=> $stable(cnt_q));

  // R12
  sleep_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |=> ($stable(base_q) && $stable(cnt_q) && $stable(act_q) && $stable(drive_q)));
endmodule

// File: tb/sync_burst_sram_tb.sv
module sync_burst_sram_tb_top;
  localparam int CLK_P = 10;
  localparam int AW = 6, LANES = 2, LW = 9, DW = LANES * LW;

  typedef struct packed {
    logic          pstb_n, cstb_n, adv_n;
    logic [2:0]    ce;      // {cs1_n, cs2, cs3_n}
    logic          gwe_n, bwe_n;
    logic [1:0]    lane_n;
    logic [AW-1:0] addr;
    logic [DW-1:0] wd;
    logic          eoe;
    logic [DW-1:0] ed;      // output after this edge
  } vec_t;

  // linear order; selected = 3'b010
  localparam vec_t VECS [17] = '{
    '{1'b1,1'b0,1'b1,3'b010,1'b0,1'b1,2'b11,6'h08,18'h11111,1'b0,18'h00000}, // R4 R10 begin write
    '{1'b1,1'b1,1'b0,3'b010,1'b0,1'b1,2'b11,6'h00,18'h22222,1'b0,18'h00000}, // R5 next -> 9
    '{1'b1,1'b1,1'b0,3'b010,1'b0,1'b1,2'b11,6'h00,18'h33333,1'b0,18'h00000}, // R5 next -> 10
    '{1'b1,1'b1,1'b1,3'b010,1'b0,1'b1,2'b11,6'h00,18'h04444,1'b0,18'h00000}, // R5 hold -> 10
    '{1'b0,1'b1,1'b1,3'b010,1'b0,1'b1,2'b11,6'h09,18'h3FFFF,1'b0,18'h00000}, // R2 read despite write
    '{1'b1,1'b1,1'b0,3'b010,1'b1,1'b1,2'b11,6'h00,18'h00000,1'b1,18'h22222}, // R9 R13 -> 10
    '{1'b1,1'b1,1'b0,3'b010,1'b1,1'b1,2'b11,6'h00,18'h00000,1'b1,18'h04444}, // R13 -> 11
    '{1'b1,1'b1,1'b0,3'b010,1'b1,1'b1,2'b11,6'h00,18'h00000,1'b1,18'h00000}, // R13 wrap -> 8
    '{1'b1,1'b0,1'b1,3'b010,1'b1,1'b0,2'b10,6'h08,18'h3FFFF,1'b1,18'h11111}, // R7 lane0 write
    '{1'b1,1'b0,1'b1,3'b010,1'b1,1'b0,2'b11,6'h08,18'h3FFFF,1'b0,18'h00000}, // R6 gate only = read
    '{1'b1,1'b0,1'b1,3'b110,1'b0,1'b1,2'b11,6'h08,18'h3FFFF,1'b1,18'h111FF}, // R3 cs1 high deselect
    '{1'b1,1'b1,1'b0,3'b010,1'b0,1'b1,2'b11,6'h08,18'h3FFFF,1'b0,18'h00000}, // R8 R5 stays deselected
    '{1'b0,1'b1,1'b1,3'b000,1'b1,1'b1,2'b11,6'h08,18'h00000,1'b0,18'h00000}, // R3 R1 pstb unselected
    '{1'b1,1'b0,1'b1,3'b010,1'b1,1'b0,2'b01,6'h0A,18'h3FFFF,1'b0,18'h00000}, // R7 lane1 write
    '{1'b1,1'b0,1'b1,3'b010,1'b1,1'b1,2'b11,6'h0A,18'h00000,1'b0,18'h00000}, // R9 read after write
    '{1'b1,1'b0,1'b1,3'b011,1'b1,1'b1,2'b11,6'h0A,18'h00000,1'b1,18'h3FE44}, // R1 R3 cs3 high
    '{1'b1,1'b1,1'b0,3'b010,1'b1,1'b1,2'b11,6'h0A,18'h00000,1'b0,18'h00000}  // R8 float
  };

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic cs1_n_i, cs2_i, cs3_n_i, pstb_n_i, cstb_n_i, adv_n_i, gwe_n_i, bwe_n_i;
  logic [LANES-1:0] lane_we_n_i;
  logic lin_mode_i, oe_n_i, sleep_i;
  logic [AW-1:0] addr_i;
  logic [DW-1:0] wdata_i, rdata_o;
  logic rdata_oe_o;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk_i = ~clk_i;

  sync_burst_sram #(.AW(AW), .LANES(LANES), .LW(LW)) dut_i (.*);

  task automatic drive(input vec_t v);
    pstb_n_i = v.pstb_n; cstb_n_i = v.cstb_n; adv_n_i = v.adv_n;
    {cs1_n_i, cs2_i, cs3_n_i} = v.ce;
    gwe_n_i = v.gwe_n; bwe_n_i = v.bwe_n; lane_we_n_i = v.lane_n;
    addr_i = v.addr; wdata_i = v.wd;
  endtask

  task automatic tick();
    @(posedge clk_i); @(negedge clk_i);
  endtask

  task automatic chk(input string tag, input logic eoe, input logic [DW-1:0] ed);
    n_chk++;
    if (rdata_oe_o !== eoe || rdata_o !== ed) begin
      n_bad++;
      $display("FAIL %s: got oe=%b data=%h exp oe=%b data=%h", tag, rdata_oe_o, rdata_o, eoe, ed);
    end
  endtask

  function automatic vec_t mk(input logic p, input logic c, input logic a, input logic g,
                              input logic [AW-1:0] ad, input logic [DW-1:0] d);
    return '{p, c, a, 3'b010, g, 1'b1, 2'b11, ad, d, 1'b0, '0};
  endfunction

  task automatic rd_chk(input logic [AW-1:0] ad, input logic [DW-1:0] ed, input string tag);
    drive(mk(1'b1, 1'b0, 1'b1, 1'b1, ad, '0)); tick();
    drive(mk(1'b1, 1'b1, 1'b1, 1'b1, ad, '0)); tick();
    chk(tag, 1'b1, ed);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 20000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout exp completion");
    finish_run();
  end

  initial begin
    drive(mk(1'b1, 1'b1, 1'b1, 1'b1, '0, '0));
    lin_mode_i = 1'b1; oe_n_i = 1'b0; sleep_i = 1'b0;
    @(negedge clk_i); @(negedge clk_i);
    chk("R14 reset", 1'b0, '0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int i = 0; i < 17; i++) begin
      drive(VECS[i]); tick();
      chk($sformatf("vec %0d", i), VECS[i].eoe, VECS[i].ed);
    end

    // R13 interleaved order from base 0x21: 21,20,23,22
    lin_mode_i = 1'b0;
    drive(mk(1'b1, 1'b0, 1'b1, 1'b0, 6'h21, 18'h0A0A0)); tick();
    drive(mk(1'b1, 1'b1, 1'b0, 1'b0, 6'h00, 18'h0B0B0)); tick();
    drive(mk(1'b1, 1'b1, 1'b0, 1'b0, 6'h00, 18'h0C0C0)); tick();
    drive(mk(1'b1, 1'b1, 1'b0, 1'b0, 6'h00, 18'h0D0D0)); tick();
    rd_chk(6'h20, 18'h0B0B0, "R13 ilv step1");
    rd_chk(6'h23, 18'h0C0C0, "R13 ilv step2");
    rd_chk(6'h22, 18'h0D0D0, "R13 ilv step3");

    // R11 asynchronous output enable
    oe_n_i = 1'b1; #1;
    chk("R11 oe high", 1'b0, '0);
    oe_n_i = 1'b0; #1;
    chk("R11 oe low", 1'b1, 18'h0D0D0);

    // R12 sleep ignores a write and holds outputs
    sleep_i = 1'b1;
    drive(mk(1'b1, 1'b0, 1'b1, 1'b0, 6'h22, 18'h3FFFF)); tick(); tick();
    chk("R12 sleep hold", 1'b1, 18'h0D0D0);
    sleep_i = 1'b0;
    rd_chk(6'h22, 18'h0D0D0, "R12 no write in sleep");

    finish_run();
  end
endmodule